// File: doc/BRIEF.md
# LCD Scan Timing Generator

This block produces the line and frame timing for a monochrome LCD panel controller. A set of parameter inputs describes the panel: how many characters sit on a line, how wide one character field is in pixels, how many display-memory bytes make up a line, how many byte-times the whole line lasts including blanking, how many scan lines form a frame, and how many pixels the visible line holds. Every parameter input carries its effective value minus one.

From these the block counts oscillator clocks. It emits a one-clock line pulse at the end of every scan line and a frame flag that toggles once per frame. It also drives a fetch window that is high during the byte-fetch part of each line. A validity checker looks at the captured parameters. If they contradict each other, it raises an error flag and holds the scan still until a consistent set is presented. Parameters are captured only when reset is released, at the end of a frame, or while an invalid set is held. Software may therefore rewrite them at any time without corrupting the frame in progress.

There is no data stream at this block's boundary, so every pin is a plain level or pulse, with no valid/ready handshake and no back-pressure.

Top module: `lcd_scan_gen`

## Requirements
- R1: Each parameter input holds its effective value minus one. The effective value of a field is the field plus one, and every count below uses effective values.
- R2: The bytes per line must equal the character field width divided by 8 and rounded up, multiplied by the characters per line. If they differ, `cfg_err` is high.
- R3: The total line length must be at least the bytes per line plus 4. If it is smaller, `cfg_err` is high. Equality is legal.
- R4: With a valid set, a scan line lasts total line length × 9 + 1 clocks. `line_pulse` is high for exactly the last clock of each line.
- R5: A frame is the lines-per-frame count of scan lines. `frame_flag` changes value at the clock edge that ends the line pulse of the frame's last line, and at no other time.
- R6: `fetch_win` is high for the first bytes-per-line × 9 clocks of each line and low for the rest of the line.
- R7: The visible pixel count must not exceed character field width × characters per line. If it does, `cfg_err` is high.
- R8: The parameter inputs are captured at the first clock after reset and at the clock edge that ends a frame. A change at any other time has no effect on the line or frame timing until the next frame end.
- R9: While the captured set is invalid, `line_pulse` and `fetch_win` stay low and `frame_flag` holds. The inputs are then re-captured on every clock. Once a valid set is captured, scanning starts at clock 0 of line 0 in the following cycle.
- R10: During reset all four outputs are low, and `cfg_err` stays low until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chars_m1 | input | CHAR_W | Characters per line, minus one |
| cfg_fx_m1 | input | FX_W | Character field width in pixels, minus one |
| cfg_bytes_m1 | input | CHAR_W | Display bytes per line, minus one |
| cfg_total_m1 | input | CHAR_W | Total line length in byte-times, minus one |
| cfg_lines_m1 | input | LINE_W | Scan lines per frame, minus one |
| cfg_hpix_m1 | input | HPIX_W | Visible pixels per line, minus one |
| line_pulse | output | 1 | One-clock pulse at the last clock of every line |
| frame_flag | output | 1 | Toggles once per frame |
| fetch_win | output | 1 | High during the byte-fetch part of each line |
| cfg_err | output | 1 | Captured parameter set is inconsistent |

## Verification
Three events share one clock edge: the line pulse of a frame's last line, the toggle of the frame flag, and the capture of new parameters. The bench provokes this by rewriting the parameters in the middle of a frame, and by shortening the frame so that the boundary arrives often. A scoreboard model predicts each cycle's outputs from the requirements. It therefore flags a flag toggle that comes a cycle early or late, as well as an early capture, which would show up as a line length that changes in mid-frame. The error cases are also placed at the legal boundary and one step past it, so that the new set first takes effect exactly at a frame end.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // clocks spent per byte-time of the line count
  localparam int CLK_PER_COUNT = 9;
  // minimum blanking in byte-times between fetch end and line end
  localparam int BLANK_MIN = 4;
  // pixels held in one display-memory byte
  localparam int PIX_PER_BYTE = 8;

  typedef enum logic {
    SCAN_UNLOADED = 1'b0,
    SCAN_LOADED   = 1'b1
  } load_state_e;
endpackage

// File: rtl/lcd_cfg_check.sv
module lcd_cfg_check
  import lcd_scan_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int FX_W   = 4,
  parameter int LINE_W = 9,
  parameter int HPIX_W = 10,
  parameter int HC_W   = 13
) (
  input  logic [CHAR_W-1:0] chars_m1,
  input  logic [FX_W-1:0]   fx_m1,
  input  logic [CHAR_W-1:0] bytes_m1,
  input  logic [CHAR_W-1:0] total_m1,
  input  logic [LINE_W-1:0] lines_m1,
  input  logic [HPIX_W-1:0] hpix_m1,
  output logic              cfg_ok,
  output logic              bytes_ok,
  output logic              blank_ok,
  output logic              width_ok,
  output logic [HC_W-1:0]   line_clks,
  output logic [HC_W-1:0]   fetch_clks,
  output logic [LINE_W:0]   frame_lines
);
  localparam int CMP_W = FX_W + CHAR_W + HPIX_W + 2;

  logic [CMP_W-1:0] chars_e, fx_e, bytes_e, total_e, hpix_e;
  logic [CMP_W-1:0] per_char, need_bytes, vis_pix, line_full, fetch_full;

  always_comb begin
    chars_e    = CMP_W'(chars_m1) + CMP_W'(1);
    fx_e       = CMP_W'(fx_m1) + CMP_W'(1);
    bytes_e    = CMP_W'(bytes_m1) + CMP_W'(1);
    total_e    = CMP_W'(total_m1) + CMP_W'(1);
    hpix_e     = CMP_W'(hpix_m1) + CMP_W'(1);
    per_char   = (fx_e + CMP_W'(PIX_PER_BYTE - 1)) / CMP_W'(PIX_PER_BYTE);
    need_bytes = per_char * chars_e;
    vis_pix    = fx_e * chars_e;
    line_full  = total_e * CMP_W'(CLK_PER_COUNT) + CMP_W'(1);
    fetch_full = bytes_e * CMP_W'(CLK_PER_COUNT);
  end

  assign bytes_ok    = (need_bytes == bytes_e);
  assign blank_ok    = (total_e >= bytes_e + CMP_W'(BLANK_MIN));
  assign width_ok    = (hpix_e <= vis_pix);
  assign cfg_ok      = bytes_ok && blank_ok && width_ok;
  assign line_clks   = HC_W'(line_full);
  assign fetch_clks  = HC_W'(fetch_full);
  assign frame_lines = (LINE_W+1)'(lines_m1) + (LINE_W+1)'(1);
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int HC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [HC_W-1:0] line_clks,
  input  logic [HC_W-1:0] fetch_clks,
  output logic            lp_o,
  output logic            fetch_o
);
  logic [HC_W-1:0] hcnt_q;
  logic            at_end;

  assign at_end  = (hcnt_q == line_clks - HC_W'(1));
  assign lp_o    = run_i && at_end;
  assign fetch_o = run_i && (hcnt_q < fetch_clks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hcnt_q <= '0;
    else if (!run_i)  hcnt_q <= '0;
    else if (at_end)  hcnt_q <= '0;
    else              hcnt_q <= hcnt_q + HC_W'(1);
  end

  // the pulse never lasts two clocks
  assert_lp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lp_o |=> !lp_o);
  // blanking keeps the fetch window clear of the line end
  assert_fetch_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_o |-> !fetch_o);
  // a new line opens with the fetch window
  assert_fetch_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(lp_o)) |-> fetch_o);
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int LINE_W = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          lp_i,
  input  logic [LINE_W:0] frame_lines,
  output logic          frame_end_o,
  output logic          fr_o
);
  logic [LINE_W:0] vcnt_q;
  logic            last_line;

  assign last_line   = (vcnt_q == frame_lines - (LINE_W+1)'(1));
  assign frame_end_o = lp_i && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            vcnt_q <= '0;
    else if (!run_i)       vcnt_q <= '0;
    else if (frame_end_o)  vcnt_q <= '0;
    else if (lp_i)         vcnt_q <= vcnt_q + (LINE_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fr_o <= 1'b0;
    else if (frame_end_o) fr_o <= ~fr_o;
  end

  // the flag only moves right after a line pulse
  assert_fr_after_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_o != $past(fr_o)) |-> $past(lp_i));
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int FX_W   = 4,
  parameter int LINE_W = 9,
  parameter int HPIX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] cfg_chars_m1,
  input  logic [FX_W-1:0]   cfg_fx_m1,
  input  logic [CHAR_W-1:0] cfg_bytes_m1,
  input  logic [CHAR_W-1:0] cfg_total_m1,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic [HPIX_W-1:0] cfg_hpix_m1,
  output logic              line_pulse,
  output logic              frame_flag,
  output logic              fetch_win,
  output logic              cfg_err
);
  localparam int HC_W = CHAR_W + 5;

  load_state_e       state_q;
  logic [CHAR_W-1:0] chars_q, bytes_q, total_q;
  logic [FX_W-1:0]   fx_q;
  logic [LINE_W-1:0] lines_q;
  logic [HPIX_W-1:0] hpix_q;

  logic              cfg_ok, bytes_ok, blank_ok, width_ok;
  logic [HC_W-1:0]   line_clks, fetch_clks;
  logic [LINE_W:0]   frame_lines;
  logic              run, frame_end, capture;

  lcd_cfg_check #(
    .CHAR_W(CHAR_W), .FX_W(FX_W), .LINE_W(LINE_W), .HPIX_W(HPIX_W), .HC_W(HC_W)
  ) u_check (
    .chars_m1(chars_q), .fx_m1(fx_q), .bytes_m1(bytes_q), .total_m1(total_q),
    .lines_m1(lines_q), .hpix_m1(hpix_q),
    .cfg_ok(cfg_ok), .bytes_ok(bytes_ok), .blank_ok(blank_ok), .width_ok(width_ok),
    .line_clks(line_clks), .fetch_clks(fetch_clks), .frame_lines(frame_lines)
  );

  assign run     = (state_q == SCAN_LOADED) && cfg_ok;
  assign cfg_err = (state_q == SCAN_LOADED) && !cfg_ok;
  assign capture = (state_q == SCAN_UNLOADED) || !cfg_ok || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_UNLOADED;
      chars_q <= '0;
      fx_q    <= '0;
      bytes_q <= '0;
      total_q <= '0;
      lines_q <= '0;
      hpix_q  <= '0;
    end else begin
      state_q <= SCAN_LOADED;
      if (capture) begin
        chars_q <= cfg_chars_m1;
        fx_q    <= cfg_fx_m1;
        bytes_q <= cfg_bytes_m1;
        total_q <= cfg_total_m1;
        lines_q <= cfg_lines_m1;
        hpix_q  <= cfg_hpix_m1;
      end
    end
  end

  lcd_line_timer #(.HC_W(HC_W)) u_line (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .line_clks(line_clks), .fetch_clks(fetch_clks),
    .lp_o(line_pulse), .fetch_o(fetch_win)
  );

  lcd_frame_timer #(.LINE_W(LINE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run_i(run), .lp_i(line_pulse),
    .frame_lines(frame_lines), .frame_end_o(frame_end), .fr_o(frame_flag)
  );

  // an invalid set keeps the scan silent
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!line_pulse && !fetch_win));
  // the captured set only moves at a frame end
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == SCAN_LOADED && $past(cfg_ok) && !$past(frame_end))
      |-> $stable({chars_q, fx_q, bytes_q, total_q, lines_q, hpix_q}));
  // each failing rule alone is enough to flag the set
  assert_rules_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SCAN_LOADED && !(bytes_ok && blank_ok && width_ok)) |-> cfg_err);
endmodule

// File: tb/lcd_scan_gen_test.sv
module lcd_scan_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_chars_m1 = '0, cfg_bytes_m1 = '0, cfg_total_m1 = '0;
  logic [3:0] cfg_fx_m1 = '0;
  logic [8:0] cfg_lines_m1 = '0;
  logic [9:0] cfg_hpix_m1 = '0;
  logic       line_pulse, frame_flag, fetch_win, cfg_err;

  always #2.5 clk = ~clk;

  lcd_scan_gen uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_chars_m1(cfg_chars_m1), .cfg_fx_m1(cfg_fx_m1),
    .cfg_bytes_m1(cfg_bytes_m1), .cfg_total_m1(cfg_total_m1),
    .cfg_lines_m1(cfg_lines_m1), .cfg_hpix_m1(cfg_hpix_m1),
    .line_pulse(line_pulse), .frame_flag(frame_flag),
    .fetch_win(fetch_win), .cfg_err(cfg_err)
  );

  typedef struct {
    bit    lp;
    bit    fetch;
    bit    fr;
    bit    err;
    string err_tag;
    string phase;
  } exp_t;

  exp_t  sb_q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string phase = "R10";

  // model state, effective values
  bit m_loaded = 0;
  int m_ch, m_fx, m_by, m_tot, m_ln, m_hp;
  int m_h = 0, m_v = 0;
  bit m_fr = 0;

  function automatic string rule_break(int fx, int ch, int by, int tot, int hp);
    if (((fx + 7) / 8) * ch != by) return "R2";
    if (tot < by + 4) return "R3";
    if (hp > fx * ch) return "R7";
    return "";
  endfunction

  task automatic model_capture();
    m_ch  = int'(cfg_chars_m1) + 1;
    m_fx  = int'(cfg_fx_m1) + 1;
    m_by  = int'(cfg_bytes_m1) + 1;
    m_tot = int'(cfg_total_m1) + 1;
    m_ln  = int'(cfg_lines_m1) + 1;
    m_hp  = int'(cfg_hpix_m1) + 1;
  endtask

  // reference model: one expected item per clock edge
  always @(posedge clk) begin
    automatic exp_t  e;
    automatic string why;
    automatic bit    run;
    automatic int    len;
    if (!rst_n) begin
      m_loaded = 0; m_h = 0; m_v = 0; m_fr = 0;
    end else if (!m_loaded) begin
      model_capture(); m_loaded = 1; m_h = 0; m_v = 0;
    end else if (rule_break(m_fx, m_ch, m_by, m_tot, m_hp) != "") begin
      model_capture(); m_h = 0; m_v = 0;
    end else begin
      len = m_tot * 9 + 1;
      if (m_h == len - 1) begin
        m_h = 0;
        if (m_v == m_ln - 1) begin
          m_v = 0; m_fr = !m_fr; model_capture();
        end else m_v = m_v + 1;
      end else m_h = m_h + 1;
    end
    why = m_loaded ? rule_break(m_fx, m_ch, m_by, m_tot, m_hp) : "";
    run = m_loaded && (why == "");
    len = m_tot * 9 + 1;
    e.lp      = run && (m_h == len - 1);
    e.fetch   = run && (m_h < m_by * 9);
    e.fr      = m_fr;
    e.err     = m_loaded && (why != "");
    e.err_tag = (why == "") ? "R9" : why;
    e.phase   = phase;
    sb_q.push_back(e);
  end

  task automatic check(bit act, bit exp, string req, string what, string ph);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s (phase %s) actual=%0b expected=%0b at %0t",
               req, what, ph, act, exp, $time);
    end
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      automatic exp_t e = sb_q.pop_front();
      check(line_pulse, e.lp,    "R4",      "line_pulse", e.phase);
      check(fetch_win,  e.fetch, "R6",      "fetch_win",  e.phase);
      check(frame_flag, e.fr,    "R5",      "frame_flag", e.phase);
      check(cfg_err,    e.err,   e.err_tag, "cfg_err",    e.phase);
    end
  end

  task automatic set_cfg(int fx, int ch, int by, int tot, int ln, int hp);
    @(negedge clk); #1;
    cfg_fx_m1    = 4'(fx - 1);
    cfg_chars_m1 = 8'(ch - 1);
    cfg_bytes_m1 = 8'(by - 1);
    cfg_total_m1 = 8'(tot - 1);
    cfg_lines_m1 = 9'(ln - 1);
    cfg_hpix_m1  = 10'(hp - 1);
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    // R10: reset state, inputs already hold a valid set
    phase = "R10";
    set_cfg(8, 4, 4, 8, 4, 32);
    wait_clks(5);
    @(negedge clk); #1; rst_n = 1'b1;
    // R1: base set, effective values from minus-one fields
    phase = "R1";
    wait_clks(250);
    // R8: rewrite in mid-frame, takes effect only at frame end
    phase = "R8";
    set_cfg(8, 4, 4, 10, 3, 32);
    wait_clks(800);
    // R3: blanking one short of the minimum
    phase = "R3";
    set_cfg(8, 4, 4, 7, 3, 32);
    wait_clks(400);
    // R3 boundary: exactly bytes + 4, R9 recovery
    phase = "R9";
    set_cfg(8, 4, 4, 8, 3, 32);
    wait_clks(400);
    // R2: wide field needs two bytes per character
    phase = "R2";
    set_cfg(9, 4, 4, 12, 2, 32);
    wait_clks(300);
    set_cfg(9, 4, 8, 12, 2, 32);
    wait_clks(500);
    // R7: one pixel too many, then exactly full width
    phase = "R7";
    set_cfg(9, 4, 8, 12, 2, 37);
    wait_clks(300);
    set_cfg(9, 4, 8, 12, 2, 36);
    wait_clks(500);
    // R5: frame of a single line makes every pulse a frame end
    phase = "R5";
    set_cfg(9, 4, 8, 12, 1, 36);
    wait_clks(600);
    @(negedge clk); #1;
    wait_clks(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule